// File: doc/BRIEF.md
# RTC Periodic Interrupt Rate Generator

This block produces the programmable periodic interrupt of a PC-style real-time clock. It counts edges of a 32.768 kHz time-base enable. A 4-bit rate code selects the period as a power of two of those ticks. The interrupt runs only while the periodic-enable bit of the control register is set and the rate code is nonzero.

At the end of each period the block drives a one-cycle set mask toward the flag register, which raises the periodic flag and the summary request flag. In the same cycle it raises the interrupt line, which then stays high until the flag register is read. Changing the rate code or the enable restarts the period from zero. Putting the divider chain into reset holds the count at zero.

Top module: `rtc_periodic_gen`

## Requirements
- R1: A rate code of 0 never produces a flag pulse, whatever the enable and the ticks do.
- R2: For a rate code n from 3 to 15, with the time-base tick high on every cycle, flag pulses are spaced 2^(n-1) ticks apart (4 ticks for code 3, 16384 ticks for code 15).
- R3: Rate code 1 gives the period of code 8 (128 ticks) and rate code 2 gives the period of code 9 (256 ticks).
- R4: While `per_en` is low no flag pulse is produced. When `per_en` rises again, a full period is counted before the next pulse.
- R5: A period expiry drives `flag_set_mask` to 0xC0 for exactly one cycle. Bit 7 is the request flag and bit 6 is the periodic flag. All other bits of the mask are zero, and the mask is zero in every cycle with no expiry. `irq` is high in the cycle the mask is nonzero.
- R6: `irq` stays high after a pulse until `flag_clr` is sampled high. If a pulse and `flag_clr` fall on the same edge, the pulse wins and `irq` stays high.
- R7: A change of `rate_sel` or of `per_en` restarts the count. If the change is sampled at edge E, the first pulse of the new setting appears 2^(n-1) ticks after E.
- R8: While `div_hold` is high no pulse is produced and the count is held at zero. The first pulse after release comes 2^(n-1) ticks after the first tick that follows the release.
- R9: Only cycles with `tbase_tick` high advance the count. With a tick on every second cycle, the period in clock cycles doubles.
- R10: After reset `flag_set_mask` is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase_tick | input | 1 | One-cycle enable per 32.768 kHz time-base period |
| rate_sel | input | RATE_W (4) | Periodic rate code |
| per_en | input | 1 | Periodic interrupt enable from the control register |
| div_hold | input | 1 | Divider chain in reset; holds the count at zero |
| flag_clr | input | 1 | Flag register read; drops the interrupt |
| flag_set_mask | output | FLAG_W (8) | One-cycle OR mask for the flag register |
| irq | output | 1 | Interrupt request line |

## Verification
The bench builds the block with its defaults: a 4-bit rate code, so codes up to 15 and a 14-bit counter; low-code aliasing turned on; and a level interrupt held until the flag read. Driving the time-base enable on every cycle brings even the slowest 16384-tick period within reach in a short run. A mode with a tick on every second cycle checks that only ticks advance the count. The scoreboard predicts the cycle of every pulse from the rate code and the cycle of the last change. It therefore catches wrong periods, a missed restart, pulses leaking through while disabled or held, and a lost clear of the interrupt line.

// File: rtl/rtc_pir_pkg.sv
package rtc_pir_pkg;

   // Flag register bit positions decoded by the neighbouring register file
   localparam int REQ_FLAG_BIT = 7;
   localparam int PER_FLAG_BIT = 6;

   // Control handed from the top to the period counter
   typedef struct packed {
      logic clear;   // force the count to zero this edge
      logic tick;    // time-base enable for this edge
   } cnt_ctl_t;

endpackage

// File: rtl/rtc_pir_rate_decode.sv
module rtc_pir_rate_decode #(
   parameter int RATE_W       = 4,
   parameter int CNT_W        = 14,
   parameter bit ALIAS_LOW    = 1'b1,
   parameter int ALIAS_MAX    = 2,
   parameter int ALIAS_OFFSET = 7
) (
   input  logic [RATE_W-1:0] rate_code,
   output logic              code_live,
   output logic [CNT_W-1:0]  term_cnt
);

   localparam int EXP_W = RATE_W + 1;

   logic [EXP_W-1:0] exp_sel;

   assign code_live = (rate_code != '0);

   generate
      if (ALIAS_LOW) begin : g_alias
         always_comb begin
            if (rate_code <= RATE_W'(ALIAS_MAX))
               exp_sel = {1'b0, rate_code} + EXP_W'(ALIAS_OFFSET - 1);
            else
               exp_sel = {1'b0, rate_code} - EXP_W'(1);
         end
      end else begin : g_direct
         always_comb exp_sel = {1'b0, rate_code} - EXP_W'(1);
      end
   endgenerate

   // terminal count = 2^exp - 1
   assign term_cnt = ~({CNT_W{1'b1}} << exp_sel);

endmodule

// File: rtl/rtc_pir_change_detect.sv
module rtc_pir_change_detect #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_code,
   input  logic              enable,
   output logic              restart
);

   logic [RATE_W-1:0] rate_q;
   logic              en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
         en_q   <= 1'b0;
      end else begin
         rate_q <= rate_code;
         en_q   <= enable;
      end
   end

   assign restart = (rate_code != rate_q) || (enable != en_q);

endmodule

// File: rtl/rtc_pir_period_counter.sv
module rtc_pir_period_counter
   import rtc_pir_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_ctl_t         ctl,
   input  logic [CNT_W-1:0] term_cnt,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   assign expire = ctl.tick && !ctl.clear && (cnt_q == term_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (ctl.clear)
         cnt_q <= '0;
      else if (ctl.tick)
         cnt_q <= expire ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
   import rtc_pir_pkg::*;
#(
   parameter int RATE_W       = 4,
   parameter int FLAG_W       = 8,
   parameter bit ALIAS_LOW    = 1'b1,
   parameter int ALIAS_MAX    = 2,
   parameter int ALIAS_OFFSET = 7,
   parameter bit IRQ_LEVEL    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbase_tick,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              per_en,
   input  logic              div_hold,
   input  logic              flag_clr,
   output logic [FLAG_W-1:0] flag_set_mask,
   output logic              irq
);

   localparam int CNT_W = (1 << RATE_W) - 2;
   localparam logic [FLAG_W-1:0] SET_MASK =
      FLAG_W'((1 << REQ_FLAG_BIT) | (1 << PER_FLAG_BIT));

   generate
      if (RATE_W < 3 || RATE_W > 5) begin : g_bad_rate_w
         $error("rtc_periodic_gen: RATE_W must lie in 3..5");
      end
      if (FLAG_W <= REQ_FLAG_BIT) begin : g_bad_flag_w
         $error("rtc_periodic_gen: FLAG_W too narrow for the flag bits");
      end
      if (ALIAS_LOW && (ALIAS_OFFSET + ALIAS_MAX - 1 > CNT_W)) begin : g_bad_alias
         $error("rtc_periodic_gen: aliased period exceeds counter width");
      end
   endgenerate

   logic             code_live;
   logic [CNT_W-1:0] term_cnt;
   logic             restart;
   logic             expire;
   logic             pulse_q;
   cnt_ctl_t         ctl;

   rtc_pir_rate_decode #(
      .RATE_W      (RATE_W),
      .CNT_W       (CNT_W),
      .ALIAS_LOW   (ALIAS_LOW),
      .ALIAS_MAX   (ALIAS_MAX),
      .ALIAS_OFFSET(ALIAS_OFFSET)
   ) u_decode (
      .rate_code(rate_sel),
      .code_live(code_live),
      .term_cnt (term_cnt)
   );

   rtc_pir_change_detect #(
      .RATE_W(RATE_W)
   ) u_change (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_code(rate_sel),
      .enable   (per_en),
      .restart  (restart)
   );

   assign ctl.clear = !(per_en && code_live) || restart || div_hold;
   assign ctl.tick  = tbase_tick;

   rtc_pir_period_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl),
      .term_cnt(term_cnt),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pulse_q <= 1'b0;
      else
         pulse_q <= expire;
   end

   assign flag_set_mask = pulse_q ? SET_MASK : '0;

   generate
      if (IRQ_LEVEL) begin : g_irq_level
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else if (expire)
               irq_q <= 1'b1;
            else if (flag_clr)
               irq_q <= 1'b0;
         end
         assign irq = irq_q;
      end else begin : g_irq_pulse
         assign irq = pulse_q;
      end
   endgenerate

endmodule

// File: rtl/rtc_periodic_gen_chk.sv
module rtc_periodic_gen_chk #(
   parameter int RATE_W    = 4,
   parameter int FLAG_W    = 8,
   parameter bit IRQ_LEVEL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tbase_tick,
   input logic [RATE_W-1:0] rate_sel,
   input logic              per_en,
   input logic              div_hold,
   input logic              flag_clr,
   input logic [FLAG_W-1:0] flag_set_mask,
   input logic              irq
);

   localparam logic [FLAG_W-1:0] EXP_MASK = FLAG_W'(8'hC0);

   p_zero_rate_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == '0) |=> (flag_set_mask == '0));

   p_disabled_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !per_en |=> (flag_set_mask == '0));

   p_mask_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set_mask == '0) || (flag_set_mask == EXP_MASK));

   p_irq_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set_mask != '0) |-> irq);

   p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set_mask != '0) |=> (flag_set_mask == '0));

   p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel != $past(rate_sel)) |=> (flag_set_mask == '0));

   p_hold_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      div_hold |=> (flag_set_mask == '0));

   p_tick_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tbase_tick |=> (flag_set_mask == '0));

   generate
      if (IRQ_LEVEL) begin : g_level_chk
         p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(flag_clr) && (flag_set_mask == '0)) |-> !irq);
      end
   endgenerate

endmodule

bind rtc_periodic_gen rtc_periodic_gen_chk #(
   .RATE_W   (RATE_W),
   .FLAG_W   (FLAG_W),
   .IRQ_LEVEL(IRQ_LEVEL)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tbase_tick   (tbase_tick),
   .rate_sel     (rate_sel),
   .per_en       (per_en),
   .div_hold     (div_hold),
   .flag_clr     (flag_clr),
   .flag_set_mask(flag_set_mask),
   .irq          (irq)
);

// File: tb/tb_rtc_periodic_gen.sv
`timescale 1ns/1ps
module tb_rtc_periodic_gen;

   localparam int RATE_W = 4;
   localparam int FLAG_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_half = 1'b0;
   logic              per_en = 1'b0;
   logic              div_hold = 1'b0;
   logic              flag_clr = 1'b0;
   logic [RATE_W-1:0] rate_sel = '0;
   logic              tbase_tick;
   logic [FLAG_W-1:0] flag_set_mask;
   logic              irq;

   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_req = "R10";
   int    exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign tbase_tick = tick_half ? cyc[0] : 1'b1;

   rtc_periodic_gen dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tbase_tick   (tbase_tick),
      .rate_sel     (rate_sel),
      .per_en       (per_en),
      .div_hold     (div_hold),
      .flag_clr     (flag_clr),
      .flag_set_mask(flag_set_mask),
      .irq          (irq)
   );

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // monitor: pops the predicted pulse cycle and compares
   always @(negedge clk) begin
      int e;
      if (rst_n && !done && flag_set_mask != '0) begin
         if (exp_q.size() == 0)
            check(cur_req, cyc, -1);
         else begin
            e = exp_q.pop_front();
            check(cur_req, cyc, e);
         end
         check("R5", int'(flag_set_mask), 'hC0);
         check("R5", int'(irq), 1);
      end
   end

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic finish_run(input string req, input int last);
      wait_until(last + 1);
      per_en    = 1'b0;
      tick_half = 1'b0;
      repeat (3) @(negedge clk);
      check(req, exp_q.size(), 0);
   endtask

   // driver: set a code, push the predicted pulse cycles, then stop
   task automatic run_train(input logic [3:0] code, input int period, input int npulse,
                            input bit half, input string req);
      int c0, first, sp;
      @(negedge clk);
      if (half) while (cyc % 2 != 0) @(negedge clk);
      c0    = cyc + 1;
      sp    = half ? 2 * period : period;
      first = half ? c0 + 2 * period - 1 : c0 + period;
      cur_req   = req;
      tick_half = half;
      rate_sel  = code;
      per_en    = 1'b1;
      for (int k = 0; k < npulse; k++) exp_q.push_back(first + k * sp);
      finish_run(req, first + (npulse - 1) * sp);
   endtask

   initial begin
      int c0, c1, c2;
      repeat (3) @(negedge clk);
      check("R10", int'(flag_set_mask), 0);
      check("R10", int'(irq), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10", int'(irq), 0);

      // R1: code 0 stays silent
      cur_req = "R1";
      rate_sel = 4'd0; per_en = 1'b1;
      repeat (300) @(negedge clk);
      check("R1", int'(irq), 0);
      per_en = 1'b0;

      // R4: enable low stays silent
      cur_req = "R4";
      rate_sel = 4'd3;
      repeat (100) @(negedge clk);
      check("R4", int'(irq), 0);

      // R2: several codes
      run_train(4'd3, 4, 5, 1'b0, "R2");
      run_train(4'd6, 32, 3, 1'b0, "R2");
      run_train(4'd15, 16384, 2, 1'b0, "R2");
      // R5: mask and irq on a mid code
      run_train(4'd7, 64, 2, 1'b0, "R5");
      // R3: aliased low codes
      run_train(4'd1, 128, 2, 1'b0, "R3");
      run_train(4'd2, 256, 2, 1'b0, "R3");
      // R9: tick on every second cycle
      run_train(4'd3, 4, 4, 1'b1, "R9");
      run_train(4'd5, 16, 2, 1'b1, "R9");

      // R7: rate change mid-period restarts
      @(negedge clk);
      cur_req = "R7";
      c0 = cyc + 1; rate_sel = 4'd4; per_en = 1'b1;
      exp_q.push_back(c0 + 8);
      wait_until(c0 + 11);
      rate_sel = 4'd5; c1 = cyc + 1;
      exp_q.push_back(c1 + 16);
      exp_q.push_back(c1 + 32);
      finish_run("R7", c1 + 32);

      // R4: enable toggle restarts a full period
      @(negedge clk);
      cur_req = "R4";
      c0 = cyc + 1; rate_sel = 4'd6; per_en = 1'b1;
      exp_q.push_back(c0 + 32);
      wait_until(c0 + 40);
      per_en = 1'b0;
      repeat (60) @(negedge clk);
      check("R4", exp_q.size(), 0);
      c2 = cyc + 1; per_en = 1'b1;
      exp_q.push_back(c2 + 32);
      finish_run("R4", c2 + 32);

      // R8: divider hold
      @(negedge clk);
      cur_req = "R8";
      c0 = cyc + 1; rate_sel = 4'd5; per_en = 1'b1;
      exp_q.push_back(c0 + 16);
      wait_until(c0 + 20);
      div_hold = 1'b1;
      repeat (40) @(negedge clk);
      check("R8", exp_q.size(), 0);
      div_hold = 1'b0; c1 = cyc;
      exp_q.push_back(c1 + 16);
      exp_q.push_back(c1 + 32);
      finish_run("R8", c1 + 32);

      // R6: irq held, then cleared; pulse wins over a same-edge clear
      repeat (5) @(negedge clk);
      check("R6", int'(irq), 1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      check("R6", int'(irq), 0);
      flag_clr = 1'b1;
      run_train(4'd3, 4, 4, 1'b0, "R6");
      check("R6", int'(irq), 0);
      flag_clr = 1'b0;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule